// File: doc/BRIEF.md
# Multi-Ring Thread Interrupt Presenter

This block keeps the interrupt presentation state of one hardware thread across three privilege rings: the operating-system ring, the hypervisor pool ring and the hypervisor physical ring. Each ring owns a pending-priority bitmap. The OS ring and the physical ring each also own a status register, a current-priority register and a posted-priority register, and each drives one interrupt line. The pool ring owns only its bitmap. It borrows the physical ring's status, priorities and line.

A notify strobe names a ring and a priority. The block sets that priority's pending bit, loads the ring's posted priority from the merged bitmap, and signals the interrupt when the posted value is strictly more urgent than the current one. Lower values are more urgent. An accept strobe names a ring. It lowers that ring's line and, if an event is flagged, promotes the posted priority to current, clears the pending bit and recomputes the posted priority. It then returns the old status and the new current priority in one response word.

Top module: `thread_irq_presenter`

## Requirements
- R1: After reset both interrupt lines are low, both posted priorities read 8'hFF, and an accept on an idle ring returns 16'h00FF (all statuses 0, all current priorities 8'hFF).
- R2: Notify with priority p (0..7) sets bitmap bit mask 8'h80 >> p. The posted priority becomes the index of the most significant set bit, with bit 7 counted as index 0, or 8'hFF when the bitmap is empty. An interrupt is signalled only when posted < current, strictly.
- R3: A signalled OS-ring notify sets bit 7 of the OS status and raises `irq_os` after the strobe's clock edge.
- R4: A pool-ring notify (ring code 1) loads the physical posted priority from the pool bitmap and compares it with the physical current priority. When it signals, it overwrites the physical status with 8'h40 (event code 2'b01 in bits [7:6]) and raises `irq_phys`.
- R5: A signalled physical-ring notify (ring code 2) ORs 8'h80 (event code 2'b10 in bits [7:6]) into the physical status and raises `irq_phys`.
- R6: An accept lowers that ring's line. If the ring's exception bits are set (OS: bit 7; physical: bits [7:6]), the current priority takes the posted priority and those bits are cleared.
- R7: An accept that takes an event clears the pending bit of the accepted priority and reloads the posted priority from the remaining bits. When the physical status bits [7:6] equal 2'b01, the pool bitmap is used instead of the physical one.
- R8: One cycle after an accept strobe, `acc_rsp` pulses and `acc_data` holds the pre-accept status in [15:8] and the post-accept current priority in [7:0].
- R9: An accept with no exception bits set leaves status, current priority and posted priority unchanged.
- R10: A notify and an accept in the same cycle on the same register set are resolved in favour of the accept, and the notify is dropped. The OS ring is one register set; the pool and physical rings together are the other. Strobes on different sets both take effect. An accept with ring code 1 acts on the physical set, and strobes with ring code 3 are ignored.
- R11: A notify that does not outrank the current priority still updates the bitmap and the posted priority, and it raises no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ntf_vld | input | 1 | Notify strobe |
| ntf_ring | input | 2 | Notify ring: 0 OS, 1 pool, 2 physical |
| ntf_prio | input | 3 | Notify priority, 0 most urgent |
| acc_vld | input | 1 | Accept strobe |
| acc_ring | input | 2 | Accept ring: 0 OS, 1 or 2 physical set |
| irq_os | output | 1 | OS ring interrupt line |
| irq_phys | output | 1 | Physical ring line, shared with pool events |
| os_posted | output | 8 | OS posted priority |
| phys_posted | output | 8 | Physical posted priority |
| acc_rsp | output | 1 | Accept response valid, one cycle after the strobe |
| acc_data | output | 16 | {status before accept, current priority after accept} |

## Verification
Notify and accept can fall in the same cycle, and the interesting cases are the ones where they hit the same register set. The bench drives both strobes on one falling edge for OS/OS and pool/physical. It expects the accept response to reflect the pre-notify state and the posted priority and line to stay untouched, which shows the notify was dropped. The same paired strobes on different sets must both land. This is judged by the OS line rising while the physical accept response arrives.

// File: rtl/tip_pkg.sv
package tip_pkg;
  typedef enum logic [1:0] {
    RING_OS   = 2'd0,
    RING_POOL = 2'd1,
    RING_PHYS = 2'd2,
    RING_NONE = 2'd3
  } ring_e;

  localparam logic [1:0] EV_POOL   = 2'b01;
  localparam logic [1:0] EV_PHYS   = 2'b10;
  localparam logic [7:0] PRIO_IDLE = 8'hFF;
  localparam logic [7:0] OS_EXC    = 8'h80;
  localparam logic [7:0] HV_EXC    = 8'hC0;
endpackage

// File: rtl/tip_prio_encode.sv
module tip_prio_encode #(
  parameter int NBITS = 8
) (
  input  logic [NBITS-1:0] pend,
  output logic [7:0]       prio
);
  // most significant set bit wins; bit NBITS-1 is priority 0
  always_comb begin
    prio = tip_pkg::PRIO_IDLE;
    for (int i = 0; i < NBITS; i++) begin
      if (pend[i]) prio = 8'(NBITS - 1 - i);
    end
  end
endmodule

// File: rtl/tip_regset.sv
module tip_regset #(
  parameter int NBITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ntf_en,
  input  logic       ntf_ovw,
  input  logic [7:0] ntf_code,
  input  logic [7:0] ntf_post,
  input  logic       acc_en,
  input  logic       acc_take,
  input  logic [7:0] acc_mask,
  input  logic [7:0] acc_post,
  output logic [7:0] nsr,
  output logic [7:0] pipr,
  output logic [7:0] cppr,
  output logic       irq
);
  logic [7:0] nsr_n, pipr_n, cppr_n;
  logic       irq_n;
  logic       outranks;

  assign outranks = ntf_post < cppr;

  always_comb begin
    nsr_n  = nsr;
    pipr_n = pipr;
    cppr_n = cppr;
    irq_n  = irq;
    if (acc_en) begin
      irq_n = 1'b0;
      if (acc_take) begin
        cppr_n = pipr;
        pipr_n = acc_post;
        nsr_n  = nsr & ~acc_mask;
      end
    end else if (ntf_en) begin
      pipr_n = ntf_post;
      if (outranks) begin
        nsr_n = ntf_ovw ? ntf_code : (nsr | ntf_code);
        irq_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nsr  <= '0;
      pipr <= tip_pkg::PRIO_IDLE;
      cppr <= tip_pkg::PRIO_IDLE;
      irq  <= 1'b0;
    end else begin
      nsr  <= nsr_n;
      pipr <= pipr_n;
      cppr <= cppr_n;
      irq  <= irq_n;
    end
  end

  assert_irq_needs_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (nsr != 8'h00));
  assert_accept_drops_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> !irq);
  assert_idle_accept_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_take) |=> ($stable(cppr) && $stable(nsr) && $stable(pipr)));
  assert_posted_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pipr == tip_pkg::PRIO_IDLE) || (pipr < 8'(NBITS)));
endmodule

// File: rtl/thread_irq_presenter.sv
module thread_irq_presenter #(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ntf_vld,
  input  logic [1:0]        ntf_ring,
  input  logic [PRIO_W-1:0] ntf_prio,
  input  logic              acc_vld,
  input  logic [1:0]        acc_ring,
  output logic              irq_os,
  output logic              irq_phys,
  output logic [7:0]        os_posted,
  output logic [7:0]        phys_posted,
  output logic              acc_rsp,
  output logic [15:0]       acc_data
);
  import tip_pkg::*;

  localparam int NBITS = 1 << PRIO_W;
  localparam int NRING = 3;
  localparam int NSET  = 2;

  function automatic logic [NBITS-1:0] prio_mask(input logic [7:0] p);
    logic [NBITS-1:0] m;
    m = '0;
    for (int i = 0; i < NBITS; i++) begin
      if (p == 8'(NBITS - 1 - i)) m[i] = 1'b1;
    end
    return m;
  endfunction

  ring_e nr, ar;
  logic  ntf_ok, acc_ok, ntf_set, acc_set, ntf_en;
  logic [1:0] ntf_idx, bm_sel;
  logic [NRING-1:0][NBITS-1:0] bm_q;
  logic [NSET-1:0][7:0] nsr_s, pipr_s, cppr_s;
  logic [NSET-1:0] irq_s;
  logic [NBITS-1:0] ntf_merge, acc_left;
  logic [7:0] ntf_post, acc_post, acc_nsr, acc_pipr, acc_mask, ntf_code;
  logic       ntf_ovw, acc_take;
  logic       rsp_n;
  logic [15:0] data_n;

  assign nr      = ring_e'(ntf_ring);
  assign ar      = ring_e'(acc_ring);
  assign ntf_ok  = ntf_vld && (nr != RING_NONE);
  assign acc_ok  = acc_vld && (ar != RING_NONE);
  assign ntf_set = (nr != RING_OS);
  assign acc_set = (ar != RING_OS);
  // same register set: accept wins
  assign ntf_en  = ntf_ok && !(acc_ok && (acc_set == ntf_set));
  assign ntf_idx = ntf_ok ? ntf_ring : 2'd0;

  always_comb begin
    ntf_ovw  = 1'b0;
    ntf_code = OS_EXC;
    case (nr)
      RING_POOL: begin ntf_ovw = 1'b1; ntf_code = {EV_POOL, 6'b0}; end
      RING_PHYS: ntf_code = {EV_PHYS, 6'b0};
      default:   ntf_code = OS_EXC;
    endcase
  end

  assign ntf_merge = bm_q[ntf_idx] | prio_mask(8'(ntf_prio));

  assign acc_nsr  = nsr_s[acc_set];
  assign acc_pipr = pipr_s[acc_set];
  assign acc_mask = acc_set ? HV_EXC : OS_EXC;
  assign acc_take = acc_ok && ((acc_nsr & acc_mask) != 8'h00);

  always_comb begin
    if (!acc_set)                      bm_sel = 2'(RING_OS);
    else if (acc_nsr[7:6] == EV_POOL)  bm_sel = 2'(RING_POOL);
    else                               bm_sel = 2'(RING_PHYS);
  end

  assign acc_left = bm_q[bm_sel] & ~prio_mask(acc_pipr);

  tip_prio_encode #(.NBITS(NBITS)) u_enc_ntf (.pend(ntf_merge), .prio(ntf_post));
  tip_prio_encode #(.NBITS(NBITS)) u_enc_acc (.pend(acc_left),  .prio(acc_post));

  for (genvar s = 0; s < NSET; s++) begin : g_set
    tip_regset #(.NBITS(NBITS)) u_set (
      .clk      (clk),
      .rst_n    (rst_n),
      .ntf_en   (ntf_en && (ntf_set == 1'(s))),
      .ntf_ovw  (ntf_ovw),
      .ntf_code (ntf_code),
      .ntf_post (ntf_post),
      .acc_en   (acc_ok && (acc_set == 1'(s))),
      .acc_take (acc_take),
      .acc_mask (acc_mask),
      .acc_post (acc_post),
      .nsr      (nsr_s[s]),
      .pipr     (pipr_s[s]),
      .cppr     (cppr_s[s]),
      .irq      (irq_s[s])
    );
  end

  for (genvar k = 0; k < NRING; k++) begin : g_bm
    logic [NBITS-1:0] bm_n;
    always_comb begin
      bm_n = bm_q[k];
      if (acc_take && (bm_sel == 2'(k)))
        bm_n = acc_left;
      else if (ntf_en && (ntf_idx == 2'(k)))
        bm_n = ntf_merge;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bm_q[k] <= '0;
      else        bm_q[k] <= bm_n;
    end
  end

  assign rsp_n  = acc_ok;
  assign data_n = {acc_nsr, acc_take ? acc_pipr : cppr_s[acc_set]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_rsp  <= 1'b0;
      acc_data <= '0;
    end else begin
      acc_rsp <= rsp_n;
      if (rsp_n) acc_data <= data_n;
    end
  end

  assign irq_os      = irq_s[0];
  assign irq_phys    = irq_s[1];
  assign os_posted   = pipr_s[0];
  assign phys_posted = pipr_s[1];

  assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> acc_rsp);
  assert_collision_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_ok && acc_ok && !ntf_set && !acc_set && !acc_take) |=> $stable(os_posted));
endmodule

// File: tb/thread_irq_presenter_test.sv
`timescale 1ns/1ps
module thread_irq_presenter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ntf_vld, acc_vld;
  logic [1:0]  ntf_ring, acc_ring;
  logic [2:0]  ntf_prio;
  logic        irq_os, irq_phys, acc_rsp;
  logic [7:0]  os_posted, phys_posted;
  logic [15:0] acc_data;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  thread_irq_presenter uut (
    .clk(clk), .rst_n(rst_n),
    .ntf_vld(ntf_vld), .ntf_ring(ntf_ring), .ntf_prio(ntf_prio),
    .acc_vld(acc_vld), .acc_ring(acc_ring),
    .irq_os(irq_os), .irq_phys(irq_phys),
    .os_posted(os_posted), .phys_posted(phys_posted),
    .acc_rsp(acc_rsp), .acc_data(acc_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ntf_vld = 0; acc_vld = 0;
    ntf_ring = 0; acc_ring = 0; ntf_prio = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one strobe cycle; returns at the following falling edge
  task automatic pulse(input bit nv, input logic [1:0] nrg, input logic [2:0] np,
                       input bit av, input logic [1:0] arg);
    ntf_vld = nv; ntf_ring = nrg; ntf_prio = np;
    acc_vld = av; acc_ring = arg;
    @(negedge clk);
    ntf_vld = 0; acc_vld = 0;
  endtask

  task automatic notify(input logic [1:0] r, input logic [2:0] p);
    pulse(1, r, p, 0, 0);
  endtask

  task automatic accept(input logic [1:0] r);
    pulse(0, 0, 0, 1, r);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 irq_os", {15'd0, irq_os}, 16'd0);
    check("R1 irq_phys", {15'd0, irq_phys}, 16'd0);
    check("R1 posted", {os_posted, phys_posted}, 16'hFFFF);
    accept(2'd0);
    check("R1 idle accept", acc_data, 16'h00FF);
    check("R8 rsp pulse", {15'd0, acc_rsp}, 16'd1);
  endtask

  task automatic t_os_ring();
    do_reset();
    notify(2'd0, 3'd5);
    check("R3 irq_os", {15'd0, irq_os}, 16'd1);
    check("R2 posted 5", {8'd0, os_posted}, 16'd5);
    notify(2'd0, 3'd3);
    check("R2 posted 3", {8'd0, os_posted}, 16'd3);
    accept(2'd0);
    check("R8 accept word", acc_data, 16'h8003);
    check("R6 line low", {15'd0, irq_os}, 16'd0);
    check("R7 posted recomputed", {8'd0, os_posted}, 16'd5);
    notify(2'd0, 3'd6);
    check("R11 no line", {15'd0, irq_os}, 16'd0);
    check("R11 posted 5", {8'd0, os_posted}, 16'd5);
    accept(2'd0);
    check("R9 idle accept", acc_data, 16'h0003);
    check("R9 posted kept", {8'd0, os_posted}, 16'd5);
    notify(2'd0, 3'd1);
    check("R2 outranks", {15'd0, irq_os}, 16'd1);
    accept(2'd0);
    check("R6 current from posted", acc_data, 16'h8001);
    notify(2'd0, 3'd1);
    check("R2 equal does not signal", {15'd0, irq_os}, 16'd0);
    accept(2'd0);
    check("R9 equal leaves state", acc_data, 16'h0001);
  endtask

  task automatic t_pool_overwrite();
    do_reset();
    notify(2'd2, 3'd5);
    check("R5 irq_phys", {15'd0, irq_phys}, 16'd1);
    notify(2'd1, 3'd3);
    check("R4 posted from pool", {8'd0, phys_posted}, 16'd3);
    check("R4 os line untouched", {15'd0, irq_os}, 16'd0);
    accept(2'd2);
    check("R4 overwrite status", acc_data, 16'h4003);
    check("R7 pool bitmap emptied", {8'd0, phys_posted}, 16'hFF);
  endtask

  task automatic t_pool_bitmap();
    do_reset();
    notify(2'd1, 3'd6);
    notify(2'd1, 3'd2);
    check("R4 irq_phys", {15'd0, irq_phys}, 16'd1);
    accept(2'd2);
    check("R8 pool accept word", acc_data, 16'h4002);
    check("R7 pool bitmap used", {8'd0, phys_posted}, 16'd6);
    check("R6 phys line low", {15'd0, irq_phys}, 16'd0);
  endtask

  task automatic t_phys_or();
    do_reset();
    notify(2'd1, 3'd6);
    notify(2'd2, 3'd4);
    accept(2'd2);
    check("R5 OR into status", acc_data, 16'hC004);
    check("R7 phys bitmap used", {8'd0, phys_posted}, 16'hFF);
  endtask

  task automatic t_collide();
    do_reset();
    pulse(1, 2'd0, 3'd2, 1, 2'd0);
    check("R10 OS accept wins", acc_data, 16'h00FF);
    check("R10 OS notify dropped", {7'd0, irq_os, os_posted}, 16'h00FF);
    pulse(1, 2'd1, 3'd2, 1, 2'd2);
    check("R10 pool notify dropped", {7'd0, irq_phys, phys_posted}, 16'h00FF);
    pulse(1, 2'd0, 3'd2, 1, 2'd2);
    check("R10 other set lands", {7'd0, irq_os, os_posted}, 16'h0102);
    check("R10 phys accept word", acc_data, 16'h00FF);
    notify(2'd2, 3'd3);
    accept(2'd1);
    check("R10 pool code accepts phys", acc_data, 16'h8003);
    pulse(1, 2'd3, 3'd0, 1, 2'd3);
    check("R10 ring 3 ignored", {15'd0, acc_rsp}, 16'd0);
    check("R10 ring 3 no posted change", {8'd0, phys_posted}, 16'hFF);
  endtask

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_os_ring();
    t_pool_overwrite();
    t_pool_bitmap();
    t_phys_or();
    t_collide();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule